// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is a purely combinational integer execution unit for a 32-bit core. It takes two operands and a 4-bit operation code, and it drives one result word. The operations are addition, subtraction, the three shifts, signed less-than, three bitwise logic functions, three multiply variants (low half, signed high half, unsigned high half), and a pass-through of the second operand.

The block has no clock, no state and no flags. Overflow and carry are discarded. The operation codes that have no function assigned drive a result of zero, so the output is always defined. A datapath places it between the operand multiplexers and write-back, and it settles within the same cycle as its inputs.

Top module: `int_alu`

## Requirements
- R1: Code 0 drives opa + opb, wrapped modulo 2^32.
- R2: Code 12 drives opa - opb, wrapped modulo 2^32.
- R3: Code 1 drives opa shifted left by opb[4:0], with zeros entering at bit 0. Bits 31:5 of opb are ignored.
- R4: Code 5 drives opa shifted right by opb[4:0], with zeros entering at bit 31.
- R5: Code 13 drives opa shifted right by opb[4:0], with copies of opa[31] entering at the top.
- R6: Code 2 drives 1 when opa < opb as two's-complement values, and 0 otherwise.
- R7: Code 4 drives opa XOR opb, code 6 drives opa OR opb, and code 7 drives opa AND opb.
- R8: Code 8 drives bits 31:0 of the product of opa and opb.
- R9: Code 9 drives bits 63:32 of the 64-bit product of opa and opb, both taken as signed.
- R10: Code 11 drives bits 63:32 of the 64-bit product of opa and opb, both taken as unsigned.
- R11: Code 15 drives opb unchanged.
- R12: Codes 3, 10 and 14 drive all zeros for any operand values.
- R13: The result is combinational. It follows any change on opa, opb or op_code with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; its low 5 bits are the shift amount |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |

## Verification
Every result is due in the same cycle as the stimulus, with zero register delay. The bench therefore drives the operands and the code on one clock edge and compares the result at the opposite edge, half a period later. One scenario changes the inputs between edges and samples after 1 ns, which shows that no clock is involved. A bench model built from the requirements supplies the expected values for corner operands (zero, ones, extreme signed values, shift amounts 0 and 31, and amounts with high bits set) and for random operands under every code.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op_code,
  output logic [W-1:0] result
);
  localparam int SHW = $clog2(W);

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_SLL   = 4'd1;
  localparam logic [3:0] OP_SLT   = 4'd2;
  localparam logic [3:0] OP_XOR   = 4'd4;
  localparam logic [3:0] OP_SRL   = 4'd5;
  localparam logic [3:0] OP_OR    = 4'd6;
  localparam logic [3:0] OP_AND   = 4'd7;
  localparam logic [3:0] OP_MUL   = 4'd8;
  localparam logic [3:0] OP_MULH  = 4'd9;
  localparam logic [3:0] OP_MULHU = 4'd11;
  localparam logic [3:0] OP_SUB   = 4'd12;
  localparam logic [3:0] OP_SRA   = 4'd13;
  localparam logic [3:0] OP_PASSB = 4'd15;

  logic [SHW-1:0] sh;
  logic           ext_a, ext_b;
  logic [2*W-1:0] wide_a, wide_b, prod;
  logic [W-1:0]   sra_v;
  logic           lt;

  assign sh = opb[SHW-1:0];

  // one shared multiplier; the extension bit picks signed or unsigned
  assign ext_a  = (op_code != OP_MULHU) & opa[W-1];
  assign ext_b  = (op_code != OP_MULHU) & opb[W-1];
  assign wide_a = {{W{ext_a}}, opa};
  assign wide_b = {{W{ext_b}}, opb};
  assign prod   = wide_a * wide_b;

  assign sra_v = $signed(opa) >>> sh;
  assign lt    = $signed(opa) < $signed(opb);

  always_comb begin
    case (op_code)
      OP_ADD:   result = opa + opb;
      OP_SUB:   result = opa - opb;
      OP_SLL:   result = opa << sh;
      OP_SRL:   result = opa >> sh;
      OP_SRA:   result = sra_v;
      OP_SLT:   result = {{(W-1){1'b0}}, lt};
      OP_XOR:   result = opa ^ opb;
      OP_OR:    result = opa | opb;
      OP_AND:   result = opa & opb;
      OP_MUL:   result = prod[W-1:0];
      OP_MULH,
      OP_MULHU: result = prod[2*W-1:W];
      OP_PASSB: result = opb;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   op_code,
  input logic [W-1:0] result
);
  localparam int SHW = $clog2(W);
  logic [W-1:0] low_mask, high_mask;
  assign low_mask  = (W'(1) << opb[SHW-1:0]) - W'(1);
  assign high_mask = ~({W{1'b1}} >> opb[SHW-1:0]);

  always_comb begin
    if (op_code == 4'd0)
      a_r1_add_inverse: assert (result - opb == opa);
    if (op_code == 4'd12)
      a_r2_sub_inverse: assert (result + opb == opa);
    if (op_code == 4'd1)
      a_r3_sll_low_zero: assert ((result & low_mask) == '0);
    if (op_code == 4'd5)
      a_r4_srl_high_zero: assert ((result & high_mask) == '0);
    if (op_code == 4'd13)
      a_r5_sra_sign_kept: assert (result[W-1] == opa[W-1]);
    if (op_code == 4'd2)
      a_r6_slt_is_bit: assert (result[W-1:1] == '0);
    if (op_code == 4'd15)
      a_r11_passb: assert (result == opb);
    if (op_code == 4'd3 || op_code == 4'd10 || op_code == 4'd14)
      a_r12_unused_zero: assert (result == '0);
    if (op_code == 4'd7)
      a_r7_and_subset: assert ((result & ~opa) == '0);
    if (op_code == 4'd6)
      a_r7_or_superset: assert ((result & opa) == opa);
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) chk_i (
  .opa(opa), .opb(opb), .op_code(op_code), .result(result)
);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  op_code = '0;
  logic [31:0] result;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  int_alu dut_i (.opa(opa), .opb(opb), .op_code(op_code), .result(result));

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0: return "R1";  4'd12: return "R2"; 4'd1: return "R3";
      4'd5: return "R4";  4'd13: return "R5"; 4'd2: return "R6";
      4'd4, 4'd6, 4'd7: return "R7";
      4'd8: return "R8";  4'd9: return "R9";  4'd11: return "R10";
      4'd15: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [3:0] c,
                                        input logic [31:0] a, input logic [31:0] b);
    longint          sa, sb;
    longint unsigned ua, ub;
    int              amt;
    logic [31:0]     r;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = {32'h0, a};           ub = {32'h0, b};
    amt = int'(b % 32);
    case (c)
      4'd0:  r = 32'((ua + ub) % 64'h1_0000_0000);
      4'd12: r = 32'((ua + 64'h1_0000_0000 - ub) % 64'h1_0000_0000);
      4'd1:  r = 32'((ua * (64'd1 << amt)) % 64'h1_0000_0000);
      4'd5:  r = 32'(ua / (64'd1 << amt));
      4'd13: begin
        r = 32'(ua / (64'd1 << amt));
        for (int i = 0; i < 32; i++) if (a[31] && i >= 32 - amt) r[i] = 1'b1;
      end
      4'd2:  r = (sa < sb) ? 32'd1 : 32'd0;
      4'd4:  for (int i = 0; i < 32; i++) r[i] = (a[i] != b[i]);
      4'd6:  for (int i = 0; i < 32; i++) r[i] = a[i] || b[i];
      4'd7:  for (int i = 0; i < 32; i++) r[i] = a[i] && b[i];
      4'd8:  r = 32'(ua * ub);
      4'd9:  begin longint p; p = sa * sb; r = 32'(p >>> 32); end
      4'd11: begin longint unsigned p; p = ua * ub; r = 32'(p >> 32); end
      4'd15: r = b;
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h got=%h exp=%h", req, op_code, opa, opb, result, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op_code = c; opa = a; opb = b;
    @(negedge clk);
    check(tag_of(c), model(c, a, b));
  endtask

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                               32'h7FFF_FFFF, 32'h0000_001F, 32'hFFFF_FFE1, 32'h1234_5678};

  task automatic t_reset_state;
    @(negedge clk);
    check("R1", 32'h0);
  endtask

  task automatic t_arith;
    apply(4'd0, 32'hFFFF_FFFF, 32'h1);
    check("R1", 32'h0);
    apply(4'd12, 32'h0, 32'h1);
    check("R2", 32'hFFFF_FFFF);
    apply(4'd0, 32'h7FFF_FFFF, 32'h1);
    check("R1", 32'h8000_0000);
  endtask

  task automatic t_shift;
    apply(4'd1, 32'h1, 32'hFFFF_FFE1);
    check("R3", 32'h2);
    apply(4'd5, 32'h8000_0000, 32'd31);
    check("R4", 32'h1);
    apply(4'd13, 32'h8000_0000, 32'd31);
    check("R5", 32'hFFFF_FFFF);
    apply(4'd13, 32'h4000_0000, 32'h0000_0120);
    check("R5", 32'h4000_0000);
  endtask

  task automatic t_slt;
    apply(4'd2, 32'hFFFF_FFFF, 32'h1);
    check("R6", 32'h1);
    apply(4'd2, 32'h1, 32'h8000_0000);
    check("R6", 32'h0);
    apply(4'd2, 32'h5, 32'h5);
    check("R6", 32'h0);
  endtask

  task automatic t_mul;
    apply(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R9", 32'h0);
    apply(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R10", 32'hFFFF_FFFE);
    apply(4'd9, 32'h8000_0000, 32'h8000_0000);
    check("R9", 32'h4000_0000);
    apply(4'd8, 32'hFFFF_FFFF, 32'h3);
    check("R8", 32'hFFFF_FFFD);
  endtask

  task automatic t_logic_pass;
    apply(4'd4, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R7", 32'h0FF0_0FF0);
    apply(4'd15, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    check("R11", 32'hCAFE_F00D);
  endtask

  task automatic t_unused;
    apply(4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R12", 32'h0);
    apply(4'd10, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R12", 32'h0);
    apply(4'd14, 32'h1234_5678, 32'h1);
    check("R12", 32'h0);
  endtask

  task automatic t_corners;
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(4'(c), corners[i], corners[j]);
  endtask

  task automatic t_random;
    for (int k = 0; k < 4000; k++)
      apply(4'($urandom_range(0, 15)), $urandom, $urandom);
  endtask

  task automatic t_comb;
    @(posedge clk);
    #0.5 op_code = 4'd0; opa = 32'd10; opb = 32'd20;
    #1   check("R13", 32'd30);
    opb = 32'd5;
    #1   check("R13", 32'd15);
    op_code = 4'd15;
    #0.5 check("R13", 32'd5);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_arith();
    t_shift();
    t_slt();
    t_mul();
    t_logic_pass();
    t_unused();
    t_corners();
    t_random();
    t_comb();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule